// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target-side bit engine for a single-wire, open-drain debug line. The host opens every bit slot by pulling the shared line low. The block passes the pin through a synchroniser and detects the falling edge on the target clock. It then finishes the slot by returning one data bit. For a zero it holds the line low for a fixed number of cycles and then drives it high for one cycle to speed up the rising edge. For a one it drives the line high for one cycle and lets go of it at once, so the pull-up holds the one.

The bit to send comes in through a valid/ready handshake and waits in a one-entry holding register until the host opens a slot. If the host opens a slot while that register is empty, the block leaves the line alone, so the host reads a one, and raises an underrun pulse. While a slot is in progress, falling edges are ignored. The slot ends a fixed number of cycles after it started. A done strobe marks that end.

Top module: `dbg_bit_tx`

## Requirements
- R1: After reset, pin_oe_o is 0, done_o is 0, underrun_o is 0 and bit_ready_o is 1.
- R2: A slot starts only on a falling edge of the synchronised pin. If pin_i is presented low from a falling clock edge, slot cycle k=0 is the cycle after the third rising edge that follows.
- R3: For data bit 0, pin_oe_o=1 and pin_out_o=0 in slot cycles k=0..12, which is 13 cycles.
- R4: For data bit 0, slot cycle k=13 has pin_oe_o=1 and pin_out_o=1 (the speedup pulse). pin_oe_o is 0 in k=14..15.
- R5: For data bit 1, slot cycle k=0 has pin_oe_o=1 and pin_out_o=1. pin_oe_o is 0 in k=1..15.
- R6: In slot cycle k=9, when the host samples, the line level equals the data bit being sent.
- R7: done_o is 1 for exactly one cycle, in slot cycle k=15. The block is idle from the next cycle on.
- R8: A falling edge on the pin during a slot neither restarts the slot nor changes its outputs.
- R9: A bit is taken when bit_valid_i and bit_ready_o are both 1. The held bit leaves bit_ready_o at 0 until the next slot consumes it, and bit_ready_o is 1 again in k=0.
- R10: In a slot opened with no held bit, pin_oe_o stays 0 for all 16 cycles and underrun_o is 1 only in k=0.
- R11: pin_oe_o is never 1 outside a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Sampled level of the shared debug line |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_data_i | input | 1 | Data bit value |
| bit_ready_o | output | 1 | Holding register empty, bit can be taken |
| pin_oe_o | output | 1 | Drive enable for the line |
| pin_out_o | output | 1 | Value driven when enabled |
| done_o | output | 1 | Last cycle of a slot |
| underrun_o | output | 1 | Slot opened with no bit held |

## Verification
The hardest case to reach from the ports is a second host falling edge arriving while a slot is in progress. When a zero is being sent the line is already held low, so a host pull shows nothing new. The stimulus therefore pulls the line low again a few cycles into slots that send a one or run in underrun, where the line has been released and the edge is visible. It then checks that the remaining cycles and the idle period after the slot do not change. Random slots mix data values, underruns, host pull lengths and gaps with these glitches.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_ZERO = 2'd1,
      SLOT_ONE  = 2'd2,
      SLOT_MUTE = 2'd3
   } slot_mode_e;
endpackage

// File: rtl/dbgtx_sync.sv
module dbgtx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dbgtx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgtx_hold.sv
module dbgtx_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   output logic in_ready,
   input  logic take,
   output logic has_data,
   output logic held_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         has_data <= 1'b0;
         held_bit <= 1'b1;
      end else if (take) begin
         has_data <= 1'b0;
      end else if (in_valid && !has_data) begin
         has_data <= 1'b1;
         held_bit <= in_bit;
      end
   end

   assign in_ready = !has_data;
endmodule

// File: rtl/dbgtx_seq.sv
module dbgtx_seq
   import dbgtx_pkg::*;
#(
   parameter int LOW_CYCLES   = 13,
   parameter int SPEED_CYCLES = 1,
   parameter int SLOT_CYCLES  = 16,
   parameter int CNT_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_s,
   input  logic             has_data,
   input  logic             held_bit,
   output logic             take,
   output logic             oe,
   output logic             val,
   output logic             done,
   output logic             underrun,
   output logic             busy,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST_K  = CNT_W'(SLOT_CYCLES - 1);
   localparam logic [CNT_W-1:0] LOW_END = CNT_W'(LOW_CYCLES);
   localparam logic [CNT_W-1:0] SPD_END = CNT_W'(LOW_CYCLES + SPEED_CYCLES);
   localparam logic [CNT_W-1:0] ONE_END = CNT_W'(SPEED_CYCLES);

   slot_mode_e mode;
   logic       prev_s;
   logic       fall;
   logic       start;

   assign fall  = prev_s && !pin_s;
   assign start = (mode == SLOT_IDLE) && fall;
   assign take  = start && has_data;
   assign busy  = (mode != SLOT_IDLE);
   assign done  = busy && (cnt == LAST_K);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_s <= 1'b1;
      else        prev_s <= pin_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= SLOT_IDLE;
         cnt      <= '0;
         underrun <= 1'b0;
      end else if (start) begin
         cnt      <= '0;
         underrun <= !has_data;
         if (!has_data)     mode <= SLOT_MUTE;
         else if (held_bit) mode <= SLOT_ONE;
         else               mode <= SLOT_ZERO;
      end else begin
         underrun <= 1'b0;
         if (busy) begin
            if (cnt == LAST_K) begin
               mode <= SLOT_IDLE;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   always_comb begin
      oe  = 1'b0;
      val = 1'b0;
      unique case (mode)
         SLOT_ZERO: begin
            if (cnt < LOW_END) begin
               oe = 1'b1;
            end else if (cnt < SPD_END) begin
               oe  = 1'b1;
               val = 1'b1;
            end
         end
         SLOT_ONE: begin
            if (cnt < ONE_END) begin
               oe  = 1'b1;
               val = 1'b1;
            end
         end
         default: begin
            oe  = 1'b0;
            val = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx #(
   parameter int SYNC_STAGES  = 2,
   parameter int LOW_CYCLES   = 13,
   parameter int SPEED_CYCLES = 1,
   parameter int SLOT_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic bit_valid_i,
   input  logic bit_data_i,
   output logic bit_ready_o,
   output logic pin_oe_o,
   output logic pin_out_o,
   output logic done_o,
   output logic underrun_o
);
   localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;

   generate
      if (SPEED_CYCLES < 1) begin : g_bad_speed
         $error("dbg_bit_tx: SPEED_CYCLES must be at least 1");
      end
      if (LOW_CYCLES + SPEED_CYCLES >= SLOT_CYCLES) begin : g_bad_slot
         $error("dbg_bit_tx: low time plus speedup must end before the slot does");
      end
   endgenerate

   logic             pin_s;
   logic             has_data;
   logic             held_bit;
   logic             take;
   logic             busy;
   logic [CNT_W-1:0] cnt;

   dbgtx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_i),
      .q    (pin_s)
   );

   dbgtx_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(bit_valid_i),
      .in_bit  (bit_data_i),
      .in_ready(bit_ready_o),
      .take    (take),
      .has_data(has_data),
      .held_bit(held_bit)
   );

   dbgtx_seq #(
      .LOW_CYCLES  (LOW_CYCLES),
      .SPEED_CYCLES(SPEED_CYCLES),
      .SLOT_CYCLES (SLOT_CYCLES),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s),
      .has_data(has_data),
      .held_bit(held_bit),
      .take    (take),
      .oe      (pin_oe_o),
      .val     (pin_out_o),
      .done    (done_o),
      .underrun(underrun_o),
      .busy    (busy),
      .cnt     (cnt)
   );
endmodule

// File: rtl/dbgtx_chk.sv
module dbgtx_chk (
   input logic clk,
   input logic rst_n,
   input logic oe,
   input logic val,
   input logic done,
   input logic underrun,
   input logic ready,
   input logic valid,
   input logic busy
);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !oe);

   // R4
   speedup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && val) |=> !oe);

   // R3
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe) && !val) |=> (oe && !val));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9
   accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> !ready);

   // R10
   underrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (!oe && busy));
endmodule

bind dbg_bit_tx dbgtx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .oe      (pin_oe_o),
   .val     (pin_out_o),
   .done    (done_o),
   .underrun(underrun_o),
   .ready   (bit_ready_o),
   .valid   (bit_valid_i),
   .busy    (busy)
);

// File: tb/sim_dbg_bit_tx.sv
`timescale 1ns/1ps
module sim_dbg_bit_tx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic bit_valid = 1'b0;
   logic bit_data = 1'b0;
   logic bit_ready, pin_oe, pin_out, done, underrun;
   logic line;
   int   n_tests = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   always #5 clk = ~clk;

   // open-drain line: host pull or target low drive wins, else pull-up
   assign line = host_low ? 1'b0 : ((pin_oe && !pin_out) ? 1'b0 : 1'b1);

   dbg_bit_tx u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(line),
      .bit_valid_i(bit_valid), .bit_data_i(bit_data),
      .bit_ready_o(bit_ready), .pin_oe_o(pin_oe), .pin_out_o(pin_out),
      .done_o(done), .underrun_o(underrun)
   );

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // mode: 0 = send zero, 1 = send one, 2 = underrun
   function automatic int exp_oe(int mode, int k);
      if (mode == 0) return (k <= 13) ? 1 : 0;
      if (mode == 1) return (k == 0) ? 1 : 0;
      return 0;
   endfunction

   function automatic int exp_out(int mode, int k);
      if (mode == 0) return (k == 13) ? 1 : 0;
      if (mode == 1) return (k == 0) ? 1 : 0;
      return 0;
   endfunction

   function automatic int exp_line(int mode, int k);
      if (mode == 0) return (k <= 12) ? 0 : 1;
      return 1;
   endfunction

   task automatic push(bit b);
      @(negedge clk);
      check("R9 ready before push", bit_ready, 1);
      bit_valid = 1'b1;
      bit_data  = b;
      @(negedge clk);
      bit_valid = 1'b0;
      check("R9 ready low while held", bit_ready, 0);
   endtask

   // glitch_k < 0 means no second host edge inside the slot
   task automatic slot(int mode, int hold, int glitch_k);
      if (mode != 2) push(mode[0]);
      @(negedge clk);
      host_low = 1'b1;
      for (int c = 0; c < 18; c++) begin
         int k;
         @(posedge clk);
         @(negedge clk);
         k = c - 2;
         if (c == hold - 1) host_low = 1'b0;
         if (k == glitch_k + 1) host_low = 1'b0;
         if (k < 0) begin
            check("R2 no early drive", pin_oe, 0);
         end else begin
            check(mode == 0 ? "R3/R4 zero oe" : (mode == 1 ? "R5 one oe" : "R10 mute oe"),
                  pin_oe, exp_oe(mode, k));
            if (pin_oe) check(mode == 0 ? "R3/R4 zero value" : "R5 one value",
                              pin_out, exp_out(mode, k));
            check("R7 done", done, (k == 15) ? 1 : 0);
            check("R10 underrun", underrun, (mode == 2 && k == 0) ? 1 : 0);
            if (k == 0) check("R9 ready after consume", bit_ready, 1);
            if (k == 9 && glitch_k != 9 && glitch_k != 8)
               check("R6 host sample", line, exp_line(mode, k));
            if (k == glitch_k) host_low = 1'b1;
         end
      end
      host_low = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R8/R11 idle after slot oe", pin_oe, 0);
         check("R8 no restart done", done, 0);
         check("R8 no restart underrun", underrun, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_0d1b);
      repeat (3) @(negedge clk);
      check("R1 oe at reset", pin_oe, 0);
      check("R1 ready at reset", bit_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 oe after reset", pin_oe, 0);
      check("R1 done after reset", done, 0);
      check("R1 underrun after reset", underrun, 0);
      check("R1 ready after reset", bit_ready, 1);
      // R2: line held high for a while, no slot may start
      repeat (6) begin
         @(negedge clk);
         check("R2 no start without edge", pin_oe, 0);
      end
      slot(0, 1, -1);
      slot(1, 2, -1);
      slot(2, 1, -1);
      slot(1, 1, 4);   // R8 glitch in a one slot
      slot(2, 2, 3);   // R8 glitch in a mute slot
      slot(0, 1, 6);   // R8 glitch hidden by zero drive
      for (int n = 0; n < 40; n++) begin
         int m, h, g;
         m = $urandom_range(2, 0);
         h = $urandom_range(2, 1);
         g = ($urandom_range(1, 0) == 1) ? $urandom_range(6, 3) : -1;
         slot(m, h, g);
         repeat ($urandom_range(3, 0)) @(negedge clk);
      end
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule